// File: doc/BRIEF.md
# Write-Once Programmable Clock Divider

This block derives the slow timing reference for a nonvolatile memory controller from the bus clock. Software sets it up through one 8-bit register on a simple bus with select, write and read strobes. The register holds a prescale-select bit and a 6-bit divisor. Its seven configuration bits accept only the first write after reset. A read-only loaded flag records that this write has happened. The same flag drives the permission output that enables erase and program operations.

The divided clock is not a new clock. It is a one-bus-cycle enable strobe, `fclk_stb`, that fires once per divided period. Downstream sequencing counts these strobes to time its erase and program steps. The strobe comes from two counters in series. The first is an optional fixed divide-by-8 prescaler. The second is a divider that divides by the divisor plus one. Both counters stay in reset until the loaded flag is set.

Top module: `wocd_clkdiv`

## Requirements
- R1: After reset, `pgm_erase_en` is 0 and `fclk_stb` is 0. A selected read returns 0x00.
- R2: A write happens when `bus_sel` and `bus_wr` are both high at a clock edge. The first write after reset loads `bus_wdata[6]` as the prescale select and `bus_wdata[5:0]` as the divisor. A write with `bus_sel` low has no effect.
- R3: The first write sets the loaded flag whatever the data, including 0x00. The flag then stays 1 until reset.
- R4: Any write after the first one leaves the prescale select and the divisor unchanged.
- R5: Writes to bit 7 are ignored. A read returns the live loaded flag in bit 7, the prescale select in bit 6 and the divisor in bits 5:0.
- R6: `pgm_erase_en` is 0 while the loaded flag is 0 and 1 once the flag is 1.
- R7: With the prescale select at 0, `fclk_stb` pulses for one cycle every divisor+1 bus cycles. A divisor of 0 gives a strobe in every cycle.
- R8: With the prescale select at 1, `fclk_stb` pulses for one cycle every 8×(divisor+1) bus cycles.
- R9: `fclk_stb` stays low until the loaded flag is set. Let N be the strobe period. The first strobe then falls in cycle N−1, counting the cycle right after the write edge as cycle 0.
- R10: `bus_rdata` is 0x00 unless `bus_sel` and `bus_rd` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: {loaded, prescale select, divisor} |
| pgm_erase_en | output | 1 | Erase/program permission |
| fclk_stb | output | 1 | One-cycle strobe per divided period |

## Verification
Read data is combinational, so the bench samples it in the same cycle the read strobe is driven. The flag and the enable change one edge after the write. For a period N, the first strobe is due in cycle N−1 after the write edge and each later strobe N cycles after the one before. The bench drives inputs on the falling edge and samples at that same falling edge, where the cycle index is counted from the write edge. It records the cycle index of the first three strobes and compares them with N−1, 2N−1 and 3N−1, with N computed from the data written.

// File: rtl/wocd_pkg.sv
// Package: shared widths and the configuration type for the write-once divider.
// Assumes an 8-bit register with the flag in bit 7 and the prescale select in bit 6.
package wocd_pkg;
    localparam int REG_W     = 8;
    localparam int DIV_W     = 6;
    localparam int PRE_RATIO = 8;

    typedef struct packed {
        logic             pre8;
        logic [DIV_W-1:0] div;
    } cfg_t;
endpackage

// File: rtl/wocd_cfg_reg.sv
// Write-once configuration register with a sticky loaded flag.
// Assumes wr_stb is already qualified by the bus select; the data carries only the 7 configuration bits.
module wocd_cfg_reg
    import wocd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_stb,
    input  cfg_t   wdata,
    output cfg_t   cfg,
    output logic   loaded
);
    // Capture the first write after reset and lock it out for every later write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= '0;
            loaded <= 1'b0;
        end else if (wr_stb && !loaded) begin
            cfg    <= wdata;
            loaded <= 1'b1;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> loaded); // R3
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> $stable(cfg)); // R4
endmodule

// File: rtl/wocd_prescale.sv
// Optional fixed prescaler: emits an enable every cycle, or every RATIO cycles when pre8 is set.
// Assumes run is low until the configuration is loaded; the counter is held at zero while run is low.
module wocd_prescale #(
    parameter int RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pre8,
    output logic en_o
);
    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt;

    // Free-running count modulo RATIO while running with the prescaler selected.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !pre8) begin
            cnt <= '0;
        end else begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // Pass every cycle through, or only the last count of each prescale period.
    always_comb begin
        en_o = run && (!pre8 || (cnt == LAST));
    end

    AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pre8 && en_o) |=> !en_o); // R8
endmodule

// File: rtl/wocd_divider.sv
// Programmable divider: counts the prescaler enables and strobes once every div+1 of them.
// Assumes div is stable while run is high, because the register locks after the first write.
module wocd_divider #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div,
    output logic             stb_o
);
    logic [DIV_W-1:0] cnt;

    // Advance on each enable and wrap once the count reaches the divisor.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (en_i) begin
            cnt <= (cnt == div) ? '0 : cnt + 1'b1;
        end
    end

    // Strobe on the enable that closes each divided period.
    always_comb begin
        stb_o = run && en_i && (cnt == div);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= div)); // R7
endmodule

// File: rtl/wocd_clkdiv.sv
// Top level: bus register decode, write-once configuration, prescaler and divider in series.
// Assumes a single register address; the bus select qualifies both reads and writes.
module wocd_clkdiv
    import wocd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             pgm_erase_en,
    output logic             fclk_stb
);
    cfg_t cfg;
    cfg_t wcfg;
    logic loaded;
    logic pre_en;
    logic wr_stb;
    logic unused_flag_wbit;

    // Qualify the write and drop bit 7, which is read-only.
    always_comb begin
        wr_stb           = bus_sel && bus_wr;
        wcfg             = cfg_t'(bus_wdata[REG_W-2:0]);
        unused_flag_wbit = bus_wdata[REG_W-1];
    end

    // Return {flag, configuration} on a selected read and zero otherwise.
    always_comb begin
        bus_rdata    = (bus_sel && bus_rd) ? {loaded, cfg} : '0;
        pgm_erase_en = loaded;
    end

    wocd_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .wdata  (wcfg),
        .cfg    (cfg),
        .loaded (loaded)
    );

    wocd_prescale #(.RATIO(PRE_RATIO)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (loaded),
        .pre8  (cfg.pre8),
        .en_o  (pre_en)
    );

    wocd_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (loaded),
        .en_i  (pre_en),
        .div   (cfg.div),
        .stb_o (fclk_stb)
    );

    AST_NO_EARLY_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_erase_en |-> !fclk_stb); // R9
    AST_EN_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgm_erase_en) |-> $past(bus_sel && bus_wr)); // R6
endmodule

// File: tb/tb_wocd_clkdiv.sv
module tb_wocd_clkdiv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pgm_erase_en, fclk_stb;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wocd_clkdiv dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pgm_erase_en(pgm_erase_en), .fclk_stb(fclk_stb)
    );

    function automatic int period_of(input logic [7:0] d);
        return (d[6] ? 8 : 1) * (int'(d[5:0]) + 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_rd = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Ends on the negedge right after the write edge (cycle 0).
    task automatic bus_write(input logic [7:0] d, input logic sel);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    // Called at cycle 0 after a first write; checks first three strobe positions.
    task automatic measure(input int n, input string req);
        int hits[3];
        int k = 0;
        for (int idx = 0; idx < 3 * n + 4; idx++) begin
            if (fclk_stb && k < 3) begin hits[k] = idx; k++; end
            @(negedge clk);
        end
        check({req, " strobe count"}, k, 3);
        check("R9 first strobe", hits[0], n - 1);
        check({req, " period 1"}, hits[1] - hits[0], n);
        check({req, " period 2"}, hits[2] - hits[1], n);
    endtask

    task automatic trial(input logic [7:0] d1, input logic [7:0] d2);
        logic [7:0] r;
        int n = period_of(d1);
        do_reset();
        check("R1 enable at reset", pgm_erase_en, 0);
        bus_read(r);
        check("R1 read at reset", r, 0);
        for (int i = 0; i < 3; i++) begin
            check("R9 no strobe before write", fclk_stb, 0);
            @(negedge clk);
        end
        bus_write(d1, 1'b1);
        check("R6 enable after write", pgm_erase_en, 1);
        measure(n, d1[6] ? "R8" : "R7");
        bus_read(r);
        check("R2 R5 readback", r, {1'b1, d1[6:0]});
        bus_write(d2, 1'b1);
        bus_read(r);
        check("R4 second write ignored", r, {1'b1, d1[6:0]});
        check("R3 flag sticky", pgm_erase_en, 1);
    endtask

    initial begin
        logic [7:0] r;
        void'($urandom(32'h5EED_0001));
        // Directed corners
        trial(8'h00, 8'h7F);   // R3 zero data still sets flag; R7 divide-by-1
        trial(8'h3F, 8'h00);   // R7 max divisor
        trial(8'h7F, 8'h01);   // R8 max combined period
        trial(8'h80, 8'h55);   // R5 bit 7 ignored, configuration 0
        trial(8'h40, 8'h3F);   // R8 prescale only
        // R2 unselected write and R10 unselected read
        do_reset();
        bus_write(8'h45, 1'b0);
        check("R2 unselected write flag", pgm_erase_en, 0);
        bus_read(r);
        check("R2 unselected write data", r, 0);
        bus_write(8'h45, 1'b1);
        @(negedge clk);
        bus_rd = 1'b1; bus_sel = 1'b0;
        #1 check("R10 read without select", bus_rdata, 0);
        bus_rd = 1'b0; bus_sel = 1'b1;
        #1 check("R10 select without read", bus_rdata, 0);
        bus_sel = 1'b0;
        // Random trials
        for (int t = 0; t < 20; t++) begin
            logic [7:0] a = 8'($urandom);
            logic [7:0] b = 8'($urandom);
            if (t < 6) a[6] = 1'b1;
            trial(a, b);
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule